// File: doc/BRIEF.md
# Watchdog Reset Pulse Output Stage

This block sits after a watchdog counter. When the watchdog expires it raises a one-cycle trigger. The block then drives an external reset pulse whose length is programmable in microsecond ticks. A 1 MHz tick strobe arrives on its own input, so the count does not depend on the bus clock.

One 32-bit configuration register on the register bus holds the pulse width, the pulse polarity and the pad drive mode. The polarity and drive-mode bits are guarded by key values. A plain write of a new width cannot flip them by accident, but the width field is written on every access.

The output is a level plus an output-enable. This pair lets the pad emulate either push-pull drive or open-drain drive with an external pull-up. The pad cell itself lies outside the block.

Top module: `wdt_rst_pulse`

## Requirements
- R1: After reset the register reads 0x000000FF: width 255, active-low, open-drain. Both outputs are low, so the pad is released.
- R2: A write to the register address stores wdata[WF-1:0] as the width. WF is 20, or 8 when NARROW_WIDTH=1. Read data holds the width in bits WF-1:0 and zero in bits 29:WF.
- R3: Top byte 0xA5 sets active-high and 0x5A sets active-low. Read bit 31 is 1 when active-high.
- R4: Top byte 0xA8 sets push-pull and 0x8A sets open-drain. Read bit 30 is 1 when push-pull.
- R5: Any other top-byte value leaves polarity and drive mode unchanged, and the width is still updated by the same write.
- R6: A trigger asserts the pulse on the next clock. With width N, the pulse deasserts on the (N+1)th tick after the trigger.
- R7: A trigger during an active pulse reloads the count, so N+1 further ticks are needed.
- R8: In push-pull mode, oe is always 1. The level is 1 when the active-high pulse is asserted or the active-low pulse is idle, and 0 otherwise.
- R9: In open-drain mode the level is always 0, and oe is 1 only while the line must be low. That is while an active-low pulse is asserted, or while an active-high pulse is idle.
- R10: A write to any other address changes nothing, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus and logic clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | ADDR_W | register byte address |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr (combinational) |
| trigger | input | 1 | watchdog expiry, one cycle |
| tick_1us | input | 1 | 1 MHz tick strobe, one cycle |
| rst_level | output | 1 | level presented to the pad |
| rst_oe | output | 1 | pad output-enable |

## Verification
Every width from 0 to 255 of the narrow variant is triggered and measured tick by tick. This separates a correct N+1 length from off-by-one and stuck-count faults. All 256 top-byte values are written from a known mode, and the read-back is compared with an arithmetic key decode. This separates the four keys from their near neighbours, and separates the mode bits from the always-written width. A mid-pulse retrigger, and all four polarity and drive combinations sampled both idle and asserted, distinguish a reload from a continued count and show the full output encoding table.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PUSHPULL = 8'hA8;
  localparam logic [7:0] KEY_OPENDRN  = 8'h8A;

  typedef struct packed {
    logic level;
    logic oe;
  } pad_drive_t;

  // line wants to be high when asserted-and-active-high or idle-and-active-low
  function automatic pad_drive_t encode_pad(logic asserted, logic pol_high, logic push_pull);
    pad_drive_t d;
    logic want_high;
    want_high = asserted ? pol_high : !pol_high;
    if (push_pull) begin
      d.level = want_high;
      d.oe    = 1'b1;
    end else begin
      d.level = 1'b0;
      d.oe    = !want_high;
    end
    return d;
  endfunction
endpackage

// File: rtl/wrp_cfg_reg.sv
module wrp_cfg_reg #(
  parameter int ADDR_W = 8,
  parameter int WF = 20,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18,
  parameter int DEF_WIDTH = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [WF-1:0]     width,
  output logic              pol_high,
  output logic              push_pull,
  output logic              reg_wr_hit
);
  import wrp_pkg::*;

  logic       addr_hit;
  logic [7:0] key;
  logic       unused_wdata;

  assign addr_hit     = (bus_addr == REG_OFFSET);
  assign reg_wr_hit   = addr_hit && bus_wr;
  assign key          = bus_wdata[31:24];
  assign unused_wdata = ^bus_wdata[23:WF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width     <= WF'(DEF_WIDTH);
      pol_high  <= 1'b0;
      push_pull <= 1'b0;
    end else if (reg_wr_hit) begin
      width <= bus_wdata[WF-1:0];
      case (key)
        KEY_POL_HIGH: pol_high  <= 1'b1;
        KEY_POL_LOW:  pol_high  <= 1'b0;
        KEY_PUSHPULL: push_pull <= 1'b1;
        KEY_OPENDRN:  push_pull <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_hit) begin
      bus_rdata[WF-1:0] = width;
      bus_rdata[31]     = pol_high;
      bus_rdata[30]     = push_pull;
    end
  end
endmodule

// File: rtl/wrp_pulse_timer.sv
module wrp_pulse_timer #(
  parameter int WF = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WF-1:0] width,
  input  logic          trigger,
  input  logic          tick,
  output logic          pulse_on,
  output logic          pulse_end
);
  logic [WF-1:0] remain;

  assign pulse_end = pulse_on && tick && !trigger && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_on <= 1'b0;
      remain   <= '0;
    end else if (trigger) begin
      pulse_on <= 1'b1;
      remain   <= width;
    end else if (pulse_on && tick) begin
      if (remain == '0) pulse_on <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/wrp_pad_enc.sv
module wrp_pad_enc (
  input  logic asserted,
  input  logic pol_high,
  input  logic push_pull,
  output logic level,
  output logic oe
);
  import wrp_pkg::*;
  pad_drive_t d;
  assign d     = encode_pad(asserted, pol_high, push_pull);
  assign level = d.level;
  assign oe    = d.oe;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18,
  parameter bit NARROW_WIDTH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              trigger,
  input  logic              tick_1us,
  output logic              rst_level,
  output logic              rst_oe
);
  localparam int WF = NARROW_WIDTH ? 8 : 20;

  logic [WF-1:0] width;
  logic          pol_high;
  logic          push_pull;
  logic          reg_wr_hit;
  logic          pulse_on;
  logic          pulse_end;

  wrp_cfg_reg #(.ADDR_W(ADDR_W), .WF(WF), .REG_OFFSET(REG_OFFSET), .DEF_WIDTH(255)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .width(width),
    .pol_high(pol_high), .push_pull(push_pull), .reg_wr_hit(reg_wr_hit)
  );

  wrp_pulse_timer #(.WF(WF)) u_timer (
    .clk(clk), .rst_n(rst_n), .width(width), .trigger(trigger),
    .tick(tick_1us), .pulse_on(pulse_on), .pulse_end(pulse_end)
  );

  wrp_pad_enc u_pad (
    .asserted(pulse_on), .pol_high(pol_high), .push_pull(push_pull),
    .level(rst_level), .oe(rst_oe)
  );
endmodule

// File: rtl/wdt_rst_pulse_chk.sv
module wdt_rst_pulse_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trigger,
  input logic       tick,
  input logic       reg_wr_hit,
  input logic [7:0] key,
  input logic       pol_high,
  input logic       push_pull,
  input logic       pulse_on,
  input logic       pulse_end,
  input logic       level,
  input logic       oe
);
  logic key_magic;
  assign key_magic = (key == 8'hA5) || (key == 8'h5A) || (key == 8'hA8) || (key == 8'h8A);

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n) trigger |=> pulse_on);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_on && !tick && !trigger) |=> pulse_on);
  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n) pulse_end |=> !pulse_on);
  p_keep_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_hit && !key_magic) |=> ($stable(pol_high) && $stable(push_pull)));
  p_quiet_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_hit |=> ($stable(pol_high) && $stable(push_pull)));
  p_pp_oe_r8: assert property (@(posedge clk) disable iff (!rst_n) push_pull |-> oe);
  p_od_low_r9: assert property (@(posedge clk) disable iff (!rst_n) !push_pull |-> !level);
endmodule

bind wdt_rst_pulse wdt_rst_pulse_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .tick(tick_1us),
  .reg_wr_hit(reg_wr_hit), .key(bus_wdata[31:24]), .pol_high(pol_high),
  .push_pull(push_pull), .pulse_on(pulse_on), .pulse_end(pulse_end),
  .level(rst_level), .oe(rst_oe)
);

// File: tb/wdt_rst_pulse_bench.sv
module wdt_rst_pulse_bench;
  localparam logic [7:0] REG = 8'h18;

  logic clk = 0, rst_n = 0, bus_wr = 0, trigger = 0, tick = 0;
  logic [7:0]  bus_addr = REG;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rst_level, rst_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_rst_pulse #(.ADDR_W(8), .REG_OFFSET(8'h18), .NARROW_WIDTH(1'b1)) u_wdt_rst_pulse (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trigger(trigger),
    .tick_1us(tick), .rst_level(rst_level), .rst_oe(rst_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = REG;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata; bus_addr = REG;
  endtask

  task automatic fire();
    @(negedge clk); trigger = 1;
    @(negedge clk); trigger = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  // counts ticks until the active-high push-pull level falls
  task automatic count_ticks(output int c);
    c = 0;
    while (rst_level && c < 2000) begin
      ticks(1);
      c++;
    end
  endtask

  // expected pad pair for a given pulse state and mode
  function automatic logic [1:0] exp_pad(bit asserted, bit ph, bit pp);
    bit hi;
    hi = asserted ? ph : !ph;
    return pp ? {hi, 1'b1} : {1'b0, !hi};
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int c;
    bit mph, mpp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(REG, r);
    chk(r == 32'h0000_00FF, "R1 reset read", r, 32'hFF);
    chk({rst_level, rst_oe} == 2'b00, "R1 reset pads", {rst_level, rst_oe}, 0);

    // R2 width field masking
    wr(REG, 32'h00FF_FF12);
    rd(REG, r);
    chk(r == 32'h0000_0012, "R2 width only", r, 32'h12);

    // R10 other address ignored
    wr(8'h1C, 32'hA5FF_FF33);
    rd(REG, r);
    chk(r == 32'h0000_0012, "R10 foreign write", r, 32'h12);
    rd(8'h1C, r);
    chk(r == 0, "R10 foreign read", r, 0);

    // R3 R4 keys
    wr(REG, 32'hA500_0001);
    rd(REG, r);
    chk(r == 32'h8000_0001, "R3 active-high key", r, 32'h8000_0001);
    wr(REG, 32'hA800_0002);
    rd(REG, r);
    chk(r == 32'hC000_0002, "R4 push-pull key", r, 32'hC000_0002);
    wr(REG, 32'h5A00_0003);
    rd(REG, r);
    chk(r == 32'h4000_0003, "R3 active-low key", r, 32'h4000_0003);
    wr(REG, 32'h8A00_0004);
    rd(REG, r);
    chk(r == 32'h0000_0004, "R4 open-drain key", r, 32'h4);

    // R5 exhaustive top byte sweep
    mph = 0; mpp = 0;
    for (int b = 0; b < 256; b++) begin
      wr(REG, {b[7:0], 16'h0, b[7:0] ^ 8'h3C});
      case (b[7:0])
        8'hA5: mph = 1;
        8'h5A: mph = 0;
        8'hA8: mpp = 1;
        8'h8A: mpp = 0;
        default: ;
      endcase
      rd(REG, r);
      chk(r == {mph, mpp, 22'h0, b[7:0] ^ 8'h3C}, "R5 top byte sweep", r,
          {mph, mpp, 22'h0, b[7:0] ^ 8'h3C});
    end

    // R8 R9 encoding, all four modes, idle and asserted
    for (int m = 0; m < 4; m++) begin
      wr(REG, {m[0] ? 8'hA5 : 8'h5A, 24'd50});
      wr(REG, {m[1] ? 8'hA8 : 8'h8A, 24'd50});
      @(negedge clk);
      chk({rst_level, rst_oe} == exp_pad(0, m[0], m[1]), m[1] ? "R8 idle pads" : "R9 idle pads",
          {rst_level, rst_oe}, exp_pad(0, m[0], m[1]));
      fire();
      chk({rst_level, rst_oe} == exp_pad(1, m[0], m[1]), m[1] ? "R8 active pads" : "R9 active pads",
          {rst_level, rst_oe}, exp_pad(1, m[0], m[1]));
      ticks(51);
      chk({rst_level, rst_oe} == exp_pad(0, m[0], m[1]), m[1] ? "R8 after pads" : "R9 after pads",
          {rst_level, rst_oe}, exp_pad(0, m[0], m[1]));
    end

    // R6 exhaustive width sweep, push-pull active-high
    wr(REG, 32'hA500_0000);
    wr(REG, 32'hA800_0000);
    for (int n = 0; n < 256; n++) begin
      wr(REG, {8'h00, 16'h0, n[7:0]});
      fire();
      chk(rst_level == 1, "R6 asserted after trigger", rst_level, 1);
      count_ticks(c);
      chk(c == n + 1, "R6 pulse length", c, n + 1);
    end

    // R7 retrigger reloads
    wr(REG, 32'h0000_0005);
    fire();
    ticks(3);
    chk(rst_level == 1, "R7 mid pulse", rst_level, 1);
    fire();
    count_ticks(c);
    chk(c == 6, "R7 retrigger length", c, 6);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule